// File: doc/BRIEF.md
# Programmable Stoppable Clock Divider

This block derives one output clock from a choice of up to eight source clocks. Each source is presented to it as an edge strobe in the system clock domain: a one-cycle pulse on `src_tick[i]` for every rising and every falling edge of source `i`. One source half-period is therefore one strobe. The selected source is divided by an integer ratio from 1 to 64, and the result comes out as a registered signal. All state lives in the system clock domain, so the divider maps onto ordinary flip-flops with clock enables.

Software controls the block through one 32-bit control word that is written whole and read back at any time. The word holds a divisor field, a stop bit and, when there is more than one source, a source-select field. Changes to the divisor or the source are applied only at the boundary between output periods, so the output never shows a shortened pulse. Setting the stop bit parks the output low at the end of the current period and leaves the divisor field as it was. Clearing the stop bit starts a fresh period on the next edge of the selected source.

Top module: `gated_clk_divider`

## Requirements
- R1: The divisor field is control bits 5:0 and holds the ratio minus one: field value d gives a ratio of d+1, from 1 (d=0) to 64 (d=63).
- R2: While running, one output period spans 2×ratio strobes of the selected source, so the output frequency is the source frequency divided by the ratio. The output changes only in cycles that carry a strobe of that source.
- R3: Control bit 8 is the stop bit. While it is set, the output stays low once the current period has finished. `enabled` is high exactly when bit 8 is clear.
- R4: Setting the stop bit leaves the stored divisor field unchanged, and a restart runs at that ratio with no rewrite of the field.
- R5: With NSRC=8 the source select is bits 14:12. With NSRC=4 it is bits 7:6. With NSRC=1 there is no select field and source 0 is always used.
- R6: A new divisor or source written while running takes effect only after the current output period has ended. The period in progress keeps its old high and low lengths.
- R7: A stop takes effect only at a period boundary, so the high phase in progress runs to its full length. After the stop bit clears, the output goes high on the first strobe of the selected source that follows the register update.
- R8: For an even ratio R the output is high for R strobes and low for R strobes. For an odd ratio R≥3 it is high for R−1 and low for R+1 strobes, which is one source cycle shorter high than low. For ratio 1 it is high for 1 strobe and low for 1 strobe.
- R9: After reset the control word reads 0x0000_0100: stopped, divisor field 0, source 0. Reads return every writable field as last written, and all other bits read zero. With NSRC=8, writing all ones reads back as 0x0000_713F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back |
| src_tick | input | NSRC | Edge strobes, one bit per source clock |
| clk_out | output | 1 | Divided output clock, low while stopped |
| enabled | output | 1 | High when the stop bit is clear |

## Verification
The bench measures the high and low lengths of each output pulse at ratios 1, 2, 3, 5 and 64. A design that decodes the field off by one, or that rounds the odd-ratio phases the wrong way, shows up as a wrong length. A divisor rewrite and a stop are each issued during a high phase. A design that applies them at once shows a truncated pulse, either a runt or a cut-short high phase, instead of a full one. Two further checks read the divisor field back after a stop and measure the delay from clearing the stop bit to the first rising output; these catch a stop that overwrites the field and a restart that begins mid-period or late. Running on a slower source selected through bits 14:12 catches a select field decoded from the wrong bits.

// File: rtl/ckd_pkg.sv
package ckd_pkg;
  localparam int DIV_W     = 6;
  localparam int CNT_W     = DIV_W + 1;
  localparam int STOP_POS  = 8;
  localparam int MAX_RATIO = 1 << DIV_W;

  function automatic int sel_lsb(input int nsrc);
    return (nsrc == 8) ? 12 : ((nsrc == 4) ? 6 : 0);
  endfunction

  function automatic int sel_width(input int nsrc);
    return (nsrc == 8) ? 3 : ((nsrc == 4) ? 2 : 0);
  endfunction
endpackage

// File: rtl/ckd_ctrl_reg.sv
module ckd_ctrl_reg
  import ckd_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SELQ = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [DIV_W-1:0]    cfg_div,
  output logic                cfg_stop,
  output logic [SELQ-1:0]     cfg_sel,
  output logic [31:0]         rd_data
);
  localparam int SEL_W   = sel_width(NSRC);
  localparam int SEL_LSB = sel_lsb(NSRC);

  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div  <= '0;
      cfg_stop <= 1'b1;
    end else if (wr_en) begin
      cfg_div  <= wr_data[DIV_W-1:0];
      cfg_stop <= wr_data[STOP_POS];
    end
  end

  generate
    if (SEL_W > 0) begin : g_sel
      always_ff @(posedge clk) begin
        if (rst)        cfg_sel <= '0;
        else if (wr_en) cfg_sel <= wr_data[SEL_LSB +: SEL_W];
      end
      always_comb begin
        rd_data                       = '0;
        rd_data[DIV_W-1:0]            = cfg_div;
        rd_data[STOP_POS]             = cfg_stop;
        rd_data[SEL_LSB +: SEL_W]     = cfg_sel;
      end
    end else begin : g_fixed
      assign cfg_sel = '0;
      always_comb begin
        rd_data            = '0;
        rd_data[DIV_W-1:0] = cfg_div;
        rd_data[STOP_POS]  = cfg_stop;
      end
    end
  endgenerate

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(rd_data)); // R9
endmodule

// File: rtl/ckd_src_mux.sv
module ckd_src_mux #(
  parameter int NSRC = 8,
  parameter int SELQ = 3
) (
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELQ-1:0] sel,
  output logic            tick
);
  generate
    if (NSRC > 1) begin : g_mux
      assign tick = src_tick[sel];
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign tick = src_tick[0];
    end
  endgenerate
endmodule

// File: rtl/ckd_phase_gen.sv
module ckd_phase_gen
  import ckd_pkg::*;
#(
  parameter int SELQ = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_stop,
  input  logic [SELQ-1:0]  cfg_sel,
  output logic [SELQ-1:0]  act_sel,
  output logic             running,
  output logic             clk_out
);
  logic [DIV_W-1:0] act_div;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] high_len;
  logic             boundary;

  always_comb begin
    last_idx = {act_div, 1'b1};
    cnt_nx   = cnt + 1'b1;
    if (act_div == '0)    high_len = 1;
    else if (act_div[0])  high_len = {1'b0, act_div} + 1'b1;
    else                  high_len = {1'b0, act_div};
    boundary = !running || (cnt == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      act_div <= '0;
      act_sel <= '0;
      clk_out <= 1'b0;
    end else if (tick) begin
      if (boundary) begin
        cnt <= '0;
        if (cfg_stop) begin
          running <= 1'b0;
          clk_out <= 1'b0;
        end else begin
          running <= 1'b1;
          act_div <= cfg_div;
          act_sel <= cfg_sel;
          clk_out <= 1'b1;
        end
      end else begin
        cnt     <= cnt_nx;
        clk_out <= (cnt_nx < high_len);
      end
    end
  end

  logic [CNT_W:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst || !clk_out) hi_run <= '0;
    else if (tick)       hi_run <= hi_run + 1'b1;
  end

  AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst) !$stable(clk_out) |-> $past(tick)); // R2
  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) $rose(clk_out) |-> $past(!cfg_stop)); // R7
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) !$stable(act_div) |-> (cnt == '0 && clk_out)); // R6
  AST_HIGH_MAX: assert property (@(posedge clk) disable iff (rst) hi_run <= (CNT_W+1)'(MAX_RATIO)); // R1
endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider
  import ckd_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NSRC-1:0] src_tick,
  output logic            clk_out,
  output logic            enabled
);
  localparam int SEL_W = sel_width(NSRC);
  localparam int SELQ  = (SEL_W == 0) ? 1 : SEL_W;

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_stop;
  logic [SELQ-1:0]  cfg_sel;
  logic [SELQ-1:0]  act_sel;
  logic [SELQ-1:0]  mux_sel;
  logic             running;
  logic             tick;

  ckd_ctrl_reg #(.NSRC(NSRC), .SELQ(SELQ)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_div(cfg_div), .cfg_stop(cfg_stop), .cfg_sel(cfg_sel), .rd_data(rd_data)
  );

  assign mux_sel = running ? act_sel : cfg_sel;

  ckd_src_mux #(.NSRC(NSRC), .SELQ(SELQ)) u_mux (
    .src_tick(src_tick), .sel(mux_sel), .tick(tick)
  );

  ckd_phase_gen #(.SELQ(SELQ)) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .cfg_div(cfg_div), .cfg_stop(cfg_stop),
    .cfg_sel(cfg_sel), .act_sel(act_sel), .running(running), .clk_out(clk_out)
  );

  assign enabled = ~cfg_stop;

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst) (!running && $past(!running)) |-> !clk_out); // R3
endmodule

// File: tb/gated_clk_divider_test.sv
module gated_clk_divider_test;
  localparam int CAP = 400;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } pulse_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_tick;
  logic        clk_out;
  logic        enabled;
  logic        phase = 0;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  pulse_t exp_q[$];

  gated_clk_divider #(.NSRC(8)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_tick(src_tick), .clk_out(clk_out), .enabled(enabled)
  );

  always #2.5 clk = ~clk;

  // source 0 strobes every cycle, source 2 every other cycle, the rest never
  always @(negedge clk) phase <= ~phase;
  assign src_tick = {5'b0, phase, 1'b0, 1'b1};

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_pulse(input int hi, input int lo, input string tag);
    pulse_t e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic monitor_pulse();
    int w, h, l;
    pulse_t e;
    w = 0;
    while (clk_out !== 1'b1 && w < CAP) begin @(negedge clk); w++; end
    h = 0;
    while (clk_out === 1'b1 && h < CAP) begin h++; @(negedge clk); end
    l = 0;
    while (clk_out !== 1'b1 && l < CAP) begin l++; @(negedge clk); end
    e = exp_q.pop_front();
    check(h == e.hi, e.tag, "high length", h, e.hi);
    check(l == e.lo, e.tag, "low length", l, e.lo);
  endtask

  task automatic stop_settle(input logic [31:0] cfg);
    ctrl_write(cfg | 32'h100);
    repeat (300) @(negedge clk);
    check(clk_out == 1'b0, "R3", "output low while stopped", int'(clk_out), 0);
  endtask

  task automatic run_case(input int div, input int sel, input int hi, input int lo, input string tag);
    logic [31:0] cfg;
    cfg = (32'(sel) << 12) | 32'(div);
    stop_settle(cfg);
    ctrl_write(cfg);
    expect_pulse(hi, lo, tag);
    expect_pulse(hi, lo, tag);
    monitor_pulse();
    monitor_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rd_data == 32'h100, "R9", "reset read-back", int'(rd_data), 32'h100);
    check(enabled == 1'b0, "R3", "enabled after reset", int'(enabled), 0);
    check(clk_out == 1'b0, "R3", "output after reset", int'(clk_out), 0);

    ctrl_write(32'hFFFF_FFFF);
    check(rd_data == 32'h713F, "R9", "all-ones read-back", int'(rd_data), 32'h713F);
    check(enabled == 1'b0, "R3", "enabled with stop set", int'(enabled), 0);

    run_case(0,  0, 1,  1,  "R8_ratio1");
    run_case(1,  0, 2,  2,  "R8_ratio2");
    run_case(2,  0, 2,  4,  "R8_ratio3");
    run_case(4,  0, 4,  6,  "R8_ratio5");
    run_case(63, 0, 64, 64, "R1_ratio64");
    run_case(1,  2, 4,  4,  "R5_src2_ratio2");
    run_case(2,  2, 4,  8,  "R2_src2_ratio3");
    check(enabled == 1'b1, "R3", "enabled while running", int'(enabled), 1);

    // R7: restart on the first strobe after the register update
    stop_settle(32'h1);
    ctrl_write(32'h1);
    check(clk_out == 1'b0, "R7", "output before restart strobe", int'(clk_out), 0);
    @(negedge clk);
    check(clk_out == 1'b1, "R7", "output on restart strobe", int'(clk_out), 1);

    // R7/R4: stop during a high phase finishes the period, keeps the divisor
    stop_settle(32'h7);
    ctrl_write(32'h7);
    expect_pulse(8, CAP, "R7_stop_boundary");
    fork
      monitor_pulse();
      begin
        while (clk_out !== 1'b1) @(negedge clk);
        ctrl_write(32'h107);
      end
    join
    check(rd_data[5:0] == 6'd7, "R4", "divisor after stop", int'(rd_data[5:0]), 7);
    check(enabled == 1'b0, "R3", "enabled after stop", int'(enabled), 0);
    ctrl_write(32'h7);
    expect_pulse(8, 8, "R4_restart_ratio8");
    monitor_pulse();

    // R6: divisor rewrite during a high phase waits for the period end
    stop_settle(32'h3);
    ctrl_write(32'h3);
    expect_pulse(4, 4, "R6_old_period");
    expect_pulse(2, 2, "R6_new_period");
    expect_pulse(2, 2, "R6_new_period");
    fork
      begin monitor_pulse(); monitor_pulse(); monitor_pulse(); end
      begin
        while (clk_out !== 1'b1) @(negedge clk);
        ctrl_write(32'h1);
      end
    join

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule